// File: doc/BRIEF.md
# Vectored Interrupt Router

The block collects a parameterised number of level interrupt vectors (256 by default) and steers each one to a set of local CPU interrupt pins. Every vector owns an enable bit, a status bit, an 8-bit CPU route byte and a 4-bit pin nibble. These all sit behind a plain 32-bit register port, with writes taking effect on the clock edge and reads returning combinationally. Each CPU has sixteen pin outputs. Output `irq_out[c*16+p]` is the OR of every enabled, pending vector that targets CPU `c` and pin `p`.

The same route byte and pin nibble can be read in two ways.

- **Legacy bitmap interpretation (reset default):**
  - The low nibble of the route byte is a one-hot set of CPUs 0..3.
  - The high nibble is a node number. Only node 0 is local.
  - The pin nibble is a bitmap over pins 0..3.
- **Encoded interpretation:**
  - A configuration register can switch the route byte to a binary CPU number.
  - The same register can switch the pin nibble to a binary pin number 0..15.
  - Each switch is available only when a read-only feature register says so.

Software moves a vector by clearing its enable bit, rewriting its route byte, and setting the enable bit again.

Top module: `vec_irq_router`

## Requirements
- R1: After reset, all enable, status, route, pin and configuration state reads 0 and every output is low.
- R2: The feature register at 0x4000_0000 reads the `FEATURES` parameter in bits 3:0, with all other bits 0. Bit0 means virtual extension, bit1 enable option, bit2 pin-encode capable and bit3 CPU-encode capable. Writes to it are ignored.
- R3: The configuration register at 0x4000_0004 stores bit1 (enable option), bit2 (pin encoding) and bit3 (CPU encoding). Each stored bit reads back ANDed with the matching feature bit, and all other bits read 0.
- R4: The enable bit of vector v is bit v%32 of the word at 0x1600 + (v/32)*4. It is readable and writable.
- R5: The status bit of vector v is bit v%32 of the read-only word at 0x1800 + (v/32)*4. It reads 1 from the clock edge after which its input was high while the vector was enabled. Writes to it are ignored.
- R6: The route byte of vector v is at word 0x1C00 + (v & ~3), bits (v&3)*8 +: 8. It is readable and writable.
- R7: The pin nibble of vector v is at word 0x1E00 + (v/8)*4, bits (v%8)*4 +: 4. It is readable and writable.
- R8: With CPU encoding off, route bit k (k<4) selects CPU k, and any nonzero high nibble (remote node) selects no CPU.
- R9: With CPU encoding on, the route byte is a binary CPU number. Numbers at or above `NUM_CPU` select no CPU.
- R10: With pin encoding off, pin-nibble bit k selects pin k. With it on, the nibble is a binary pin number 0..15.
- R11: An output is the OR of all enabled, pending vectors that target it. A disabled vector drives nothing, and the output falls in the same cycle the enable bit clears.
- R12: A configuration bit whose feature bit is 0 reads 0 and leaves routing in the legacy interpretation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 32 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_in | input | NUM_VEC | Level interrupt inputs, one per vector |
| irq_out | output | NUM_CPU*16 | Per-CPU, per-pin interrupt outputs, index cpu*16+pin |

## Verification
The critical overlap is a register write landing on the same edge as a live input being latched into status. One case is clearing a vector's enable while its input stays high. The other is rewriting a route byte while the vector is pending. The bench holds the input high across the disabling write and expects the output to be low right after that edge. It then expects status to read 0 one cycle later. Reroutes under a pending vector are judged by the output changing to the new target directly after the write, with no extra latency.

// File: rtl/vir_pkg.sv
package vir_pkg;
    localparam logic [31:0] EN_BASE   = 32'h0000_1600;
    localparam logic [31:0] ST_BASE   = 32'h0000_1800;
    localparam logic [31:0] RT_BASE   = 32'h0000_1C00;
    localparam logic [31:0] PN_BASE   = 32'h0000_1E00;
    localparam logic [31:0] FEAT_ADDR = 32'h4000_0000;
    localparam logic [31:0] CFG_ADDR  = 32'h4000_0004;
    localparam int PINS_PER_CPU = 16;
    localparam int LEGACY_CPUS  = 4;
endpackage

// File: rtl/vir_route_dec.sv
module vir_route_dec
    import vir_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [7:0]                      route_byte,
    input  logic [3:0]                      pin_nib,
    input  logic                            cpu_enc,
    input  logic                            pin_enc,
    output logic [NUM_CPU*PINS_PER_CPU-1:0] hit
);
    localparam int LEG_N = (NUM_CPU < LEGACY_CPUS) ? NUM_CPU : LEGACY_CPUS;

    logic [NUM_CPU-1:0]      cpu_sel;
    logic [PINS_PER_CPU-1:0] pin_sel;

    always_comb begin
        cpu_sel = '0;
        if (cpu_enc) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                cpu_sel[c] = (32'(route_byte) == c);
            end
        end else if (route_byte[7:4] == 4'd0) begin
            for (int c = 0; c < LEG_N; c++) begin
                cpu_sel[c] = route_byte[c];
            end
        end
        pin_sel = '0;
        if (pin_enc) begin
            pin_sel[pin_nib] = 1'b1;
        end else begin
            pin_sel[3:0] = pin_nib;
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int p = 0; p < PINS_PER_CPU; p++) begin
                hit[c*PINS_PER_CPU+p] = cpu_sel[c] & pin_sel[p];
            end
        end
    end

    always_comb begin
        // R8
        if (!cpu_enc && (route_byte[7:4] != 4'd0)) begin
            remote_node_silent_chk: assert (hit == '0);
        end
        // R10
        if (cpu_enc && pin_enc) begin
            single_target_chk: assert ($onehot0(hit));
        end
    end
endmodule

// File: rtl/vir_merge.sv
module vir_merge #(
    parameter int NUM_VEC = 256,
    parameter int NUM_OUT = 64
) (
    input  logic [NUM_VEC-1:0][NUM_OUT-1:0] hits,
    input  logic [NUM_VEC-1:0]              active,
    output logic [NUM_OUT-1:0]              out
);
    always_comb begin
        out = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (active[v]) out = out | hits[v];
        end
    end
endmodule

// File: rtl/vec_irq_router.sv
module vec_irq_router
    import vir_pkg::*;
#(
    parameter int          NUM_VEC  = 256,
    parameter int          NUM_CPU  = 4,
    parameter logic [3:0]  FEATURES = 4'hF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_we,
    input  logic [31:0]                     reg_addr,
    input  logic [31:0]                     reg_wdata,
    output logic [31:0]                     reg_rdata,
    input  logic [NUM_VEC-1:0]              irq_in,
    output logic [NUM_CPU*PINS_PER_CPU-1:0] irq_out
);
    localparam int NOUT = NUM_CPU * PINS_PER_CPU;
    localparam int EN_W = NUM_VEC / 32;
    localparam int RT_W = NUM_VEC / 4;
    localparam int PN_W = NUM_VEC / 8;

    typedef struct packed {
        logic [NUM_VEC-1:0]      en;
        logic [NUM_VEC-1:0]      pend;
        logic [NUM_VEC-1:0][7:0] route;
        logic [NUM_VEC-1:0][3:0] pin;
        logic [3:1]              cfg;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_VEC-1:0][NOUT-1:0] hits;

    always_comb begin
        st_d      = st_q;
        st_d.pend = irq_in & st_q.en;
        if (reg_we) begin
            for (int w = 0; w < EN_W; w++) begin
                if (reg_addr == EN_BASE + 32'(w * 4)) st_d.en[w*32 +: 32] = reg_wdata;
            end
            for (int w = 0; w < RT_W; w++) begin
                if (reg_addr == RT_BASE + 32'(w * 4)) st_d.route[w*4 +: 4] = reg_wdata;
            end
            for (int w = 0; w < PN_W; w++) begin
                if (reg_addr == PN_BASE + 32'(w * 4)) st_d.pin[w*8 +: 8] = reg_wdata;
            end
            if (reg_addr == CFG_ADDR) st_d.cfg = reg_wdata[3:1] & FEATURES[3:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == FEAT_ADDR) reg_rdata = {28'd0, FEATURES};
        if (reg_addr == CFG_ADDR)  reg_rdata = {28'd0, st_q.cfg, 1'b0};
        for (int w = 0; w < EN_W; w++) begin
            if (reg_addr == EN_BASE + 32'(w * 4)) reg_rdata = st_q.en[w*32 +: 32];
            if (reg_addr == ST_BASE + 32'(w * 4)) reg_rdata = st_q.pend[w*32 +: 32];
        end
        for (int w = 0; w < RT_W; w++) begin
            if (reg_addr == RT_BASE + 32'(w * 4)) reg_rdata = st_q.route[w*4 +: 4];
        end
        for (int w = 0; w < PN_W; w++) begin
            if (reg_addr == PN_BASE + 32'(w * 4)) reg_rdata = st_q.pin[w*8 +: 8];
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
        vir_route_dec #(.NUM_CPU(NUM_CPU)) u_dec (
            .route_byte (st_q.route[v]),
            .pin_nib    (st_q.pin[v]),
            .cpu_enc    (st_q.cfg[3]),
            .pin_enc    (st_q.cfg[2]),
            .hit        (hits[v])
        );
    end

    vir_merge #(.NUM_VEC(NUM_VEC), .NUM_OUT(NOUT)) u_merge (
        .hits   (hits),
        .active (st_q.pend & st_q.en),
        .out    (irq_out)
    );

    // R11
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en == '0) |-> (irq_out == '0));
    // R5
    status_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & ~$past(irq_in)) == '0));
    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == CFG_ADDR) |=> $stable(st_q.cfg));
    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(st_q.en));
    // R2
    feat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == FEAT_ADDR) |-> (reg_rdata == {28'd0, FEATURES}));
endmodule

// File: tb/vec_irq_router_tb.sv
module vec_irq_router_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b, rdata;
    logic [NV-1:0] irq_in = '0;
    logic [NC*16-1:0] out_a, out_b;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rdata = sel ? rdata_b : rdata_a;

    vec_irq_router #(.NUM_VEC(NV), .NUM_CPU(NC), .FEATURES(4'hF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we & ~sel), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_a), .irq_in(irq_in), .irq_out(out_a));

    vec_irq_router #(.NUM_VEC(NV), .NUM_CPU(NC), .FEATURES(4'h3)) u_dut_nofeat (
        .clk(clk), .rst_n(rst_n), .reg_we(we & sel), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_b), .irq_in(irq_in), .irq_out(out_b));

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(string tag, logic [31:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, 64'(rdata), 64'(exp));
    endtask

    task automatic t_reset();
        check("R1 outputs", 64'(out_a), 64'd0);
        rd("R1 config", 32'h4000_0004, 32'h0);
        rd("R1 enable", 32'h1600, 32'h0);
        rd("R1 status", 32'h1800, 32'h0);
        rd("R1 route", 32'h1C00, 32'h0);
        rd("R1 pin", 32'h1E00, 32'h0);
    endtask

    task automatic t_feature();
        rd("R2 feature", 32'h4000_0000, 32'hF);
        wr(32'h4000_0000, 32'hFFFF_FFFF);
        rd("R2 feature write ignored", 32'h4000_0000, 32'hF);
    endtask

    task automatic t_config();
        wr(32'h4000_0004, 32'hFFFF_FFFF);
        rd("R3 config bits", 32'h4000_0004, 32'hE);
        wr(32'h4000_0004, 32'h0);
        rd("R3 config clear", 32'h4000_0004, 32'h0);
    endtask

    task automatic t_legacy();
        // vector 37: route word 0x1C24 byte1, pin word 0x1E10 nibble5, enable 0x1604 bit5
        wr(32'h1C24, 32'h0000_0400);
        wr(32'h1E10, 32'h0020_0000);
        irq_in[37] = 1'b1;
        wr(32'h1604, 32'h20);
        @(negedge clk);
        check("R8 R10 legacy cpu2 pin1", 64'(out_a), 64'h2_0000_0000);
        rd("R4 enable readback", 32'h1604, 32'h20);
        rd("R5 status set", 32'h1804, 32'h20);
        rd("R6 route readback", 32'h1C24, 32'h0000_0400);
        rd("R7 pin readback", 32'h1E10, 32'h0020_0000);
        wr(32'h1C24, 32'h0000_0300);
        wr(32'h1E10, 32'h0090_0000);
        check("R8 R11 legacy multi target", 64'(out_a), 64'h0009_0009);
        wr(32'h1C24, 32'h0000_1300);
        check("R8 remote node", 64'(out_a), 64'h0);
        wr(32'h1C24, 32'h0000_0300);
        wr(32'h1604, 32'h0);
        check("R11 drop with enable", 64'(out_a), 64'h0);
        @(negedge clk);
        rd("R5 status when disabled", 32'h1804, 32'h0);
        wr(32'h1804, 32'hFFFF_FFFF);
        rd("R5 status write ignored", 32'h1804, 32'h0);
        check("R11 stays quiet", 64'(out_a), 64'h0);
        irq_in[37] = 1'b0;
    endtask

    task automatic t_encoded();
        // vector 200: route word 0x1CC8 byte0, pin word 0x1E64 nibble0, enable 0x1618 bit8
        wr(32'h4000_0004, 32'hC);
        wr(32'h1CC8, 32'h03);
        wr(32'h1E64, 32'hC);
        irq_in[200] = 1'b1;
        wr(32'h1618, 32'h100);
        @(negedge clk);
        check("R9 R10 encoded cpu3 pin12", 64'(out_a), 64'h1000_0000_0000_0000);
        wr(32'h1CC8, 32'h05);
        check("R9 cpu beyond range", 64'(out_a), 64'h0);
        wr(32'h4000_0004, 32'h8);
        wr(32'h1CC8, 32'h01);
        wr(32'h1E64, 32'h7);
        check("R9 R10 cpu1 pin bitmap", 64'(out_a), 64'h7_0000);
    endtask

    task automatic t_merge();
        wr(32'h1CC8, 32'h0101);
        wr(32'h1E64, 32'h11);
        irq_in[201] = 1'b1;
        wr(32'h1618, 32'h300);
        @(negedge clk);
        check("R11 two vectors one pin", 64'(out_a), 64'h1_0000);
        irq_in[200] = 1'b0;
        @(negedge clk);
        check("R11 one source left", 64'(out_a), 64'h1_0000);
        irq_in[201] = 1'b0;
        @(negedge clk);
        check("R11 no source", 64'(out_a), 64'h0);
    endtask

    task automatic t_nofeat();
        sel = 1'b1;
        wr(32'h4000_0004, 32'hE);
        rd("R12 masked config", 32'h4000_0004, 32'h2);
        wr(32'h1C00, 32'h04);
        wr(32'h1E00, 32'h2);
        irq_in[0] = 1'b1;
        wr(32'h1600, 32'h1);
        @(negedge clk);
        check("R12 routing stays legacy", 64'(out_b), 64'h2_0000_0000);
        irq_in[0] = 1'b0;
        sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_feature();
        t_config();
        t_legacy();
        t_encoded();
        t_merge();
        t_nofeat();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule